// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block holds one architectural stack pointer register (A7) backed by three saved slots: a master/supervisor slot, a user slot and an interrupt slot. It also holds the status register and the cache-control register that steer the choice. Whenever the chosen slot changes, the block parks the live A7 in the slot that was active and loads A7 from the slot that is now chosen. The change can come from a status register write, a cache-control write or a change of the family strap.

Two selection rules exist. With the family strap high, the supervisor bit and the master bit of the status register pick one of three slots. With the strap low, a two-slot rule applies: the supervisor slot is used only when the supervisor bit and the separate-user-stack enable bit of the cache-control register are both set. Control-register moves reach any slot directly through a bank write port.

Top module: `sp_bank_sel`

## Requirements
- R1: A synchronous reset clears A7, all three slots and the cache-control register. With `SYS_MODE`=1 (default) it sets the status register to 0x2700; with `SYS_MODE`=0 it sets it to 0. The active index is derived from these reset values and the strap: 2 with the strap high, 1 with it low.
- R2: With `full_family`=1 the active index is 1 when status bit 13 (S) is 0, 0 when S=1 and status bit 12 (M)=1, and 2 when S=1 and M=0. Slot indices are 0 master/supervisor, 1 user and 2 interrupt.
- R3: With `full_family`=0 the active index is 0 only when S=1 and cache-control bit `EUSP_BIT` (default 31) is 1. In every other case it is 1, and it is never 2.
- R4: On a change of active index, the live A7 is stored in the old slot and A7 is loaded from the new slot. Returning to a slot therefore restores the value A7 had when that slot was left.
- R5: A switch takes one clock. `a7_rd_data` shows the old value during the cycle that causes the switch and the new value from the next cycle on.
- R6: A cache-control write re-evaluates the selection. With the strap low it can switch the bank. With the strap high it leaves the bank unchanged.
- R7: An A7 write in the same cycle as a switch is the value stored into the old slot.
- R8: A bank write to a slot that is not active leaves A7 unchanged. The value written appears in A7 once that slot becomes active.
- R9: A bank write to the active slot updates A7 on the next cycle. In that cycle it takes priority over an A7 write.
- R10: A bank write to the slot being switched to, in the switching cycle, is the value loaded into A7.
- R11: A status register write that leaves S and M unchanged causes no switch and leaves A7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_family | input | 1 | Strap: 1 selects the three-slot rule, 0 the two-slot rule |
| sr_wr_en | input | 1 | Status register write enable |
| sr_wr_data | input | SR_W | Status register write value |
| cacr_wr_en | input | 1 | Cache-control register write enable |
| cacr_wr_data | input | CR_W | Cache-control register write value |
| a7_wr_en | input | 1 | A7 write enable |
| a7_wr_data | input | DATA_W | A7 write value |
| bank_wr_en | input | 1 | Direct slot write enable |
| bank_wr_sel | input | 2 | Target slot index (0..2; 3 is ignored) |
| bank_wr_data | input | DATA_W | Direct slot write value |
| a7_rd_data | output | DATA_W | Registered live A7 |
| active_bank | output | 2 | Registered index of the active slot |
| sr_q | output | SR_W | Status register |
| cacr_q | output | CR_W | Cache-control register |

## Verification
The bench walks through all three slots with the strap high, writing a distinct A7 value in each slot. Restored values then show that every slot is saved and loaded separately and that no slot is aliased to another. It then lines up A7 writes and bank writes with the switching cycle. This separates the value that is saved from the value that is loaded, and shows which write wins on the active slot. Writes to the cache-control register are made with the strap high and with it low, to tell apart the two selection rules. A status write that changes only the mask and flag bits shows that bits other than S and M cannot cause a switch. A behavioural model is compared against the outputs on every clock.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  localparam int BANK_IW   = 2;
  localparam int BANK_NUM  = 3;
  localparam int SR_S_BIT  = 13;
  localparam int SR_M_BIT  = 12;

  localparam logic [BANK_IW-1:0] BANK_MSP = 2'd0;
  localparam logic [BANK_IW-1:0] BANK_USP = 2'd1;
  localparam logic [BANK_IW-1:0] BANK_ISP = 2'd2;

  // Slot choice from the mode bits for either family rule.
  function automatic logic [BANK_IW-1:0] pick_bank(input logic full,
                                                   input logic s_bit,
                                                   input logic m_bit,
                                                   input logic eusp);
    logic [BANK_IW-1:0] r;
    if (full) begin
      if (!s_bit)     r = BANK_USP;
      else if (m_bit) r = BANK_MSP;
      else            r = BANK_ISP;
    end else begin
      r = (s_bit && eusp) ? BANK_MSP : BANK_USP;
    end
    return r;
  endfunction
endpackage

// File: rtl/sp_ctrl_regs.sv
module sp_ctrl_regs #(
  parameter int SR_W     = 16,
  parameter int CR_W     = 32,
  parameter int EUSP_BIT = 31,
  parameter logic [SR_W-1:0] RESET_SR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sr_we,
  input  logic [SR_W-1:0] sr_wd,
  input  logic            cr_we,
  input  logic [CR_W-1:0] cr_wd,
  output logic            s_next,
  output logic            m_next,
  output logic            eusp_next,
  output logic [SR_W-1:0] sr_q,
  output logic [CR_W-1:0] cr_q
);
  import sp_bank_pkg::*;

  logic [SR_W-1:0] sr_d;
  logic [CR_W-1:0] cr_d;

  // Next values, reset values while reset is held.
  always_comb begin
    if (rst) begin
      sr_d = RESET_SR;
      cr_d = '0;
    end else begin
      sr_d = sr_we ? sr_wd : sr_q;
      cr_d = cr_we ? cr_wd : cr_q;
    end
  end

  assign s_next    = sr_d[SR_S_BIT];
  assign m_next    = sr_d[SR_M_BIT];
  assign eusp_next = cr_d[EUSP_BIT];

  always_ff @(posedge clk) begin
    sr_q <= sr_d;
    cr_q <= cr_d;
  end
endmodule

// File: rtl/sp_mode_decode.sv
module sp_mode_decode (
  input  logic       full_family,
  input  logic       s_next,
  input  logic       m_next,
  input  logic       eusp_next,
  output logic [1:0] bank_next
);
  import sp_bank_pkg::*;

  assign bank_next = pick_bank(full_family, s_next, m_next, eusp_next);
endmodule

// File: rtl/sp_slot_file.sv
module sp_slot_file #(
  parameter int DW    = 32,
  parameter int NSLOT = 3,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save_en,
  input  logic [IW-1:0] save_idx,
  input  logic [DW-1:0] save_data,
  input  logic          bw_en,
  input  logic [IW-1:0] bw_idx,
  input  logic [DW-1:0] bw_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot_q [NSLOT];

  // Direct bank writes win over the save of the departing A7.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (rst)
        slot_q[i] <= '0;
      else if (bw_en && bw_idx == IW'(i))
        slot_q[i] <= bw_data;
      else if (save_en && save_idx == IW'(i))
        slot_q[i] <= save_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++)
      if (rd_idx == IW'(i)) rd_data = slot_q[i];
  end
endmodule

// File: rtl/sp_bank_sel.sv
module sp_bank_sel #(
  parameter int DATA_W   = 32,
  parameter int SR_W     = 16,
  parameter int CR_W     = 32,
  parameter int EUSP_BIT = 31,
  parameter bit SYS_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_family,
  input  logic              sr_wr_en,
  input  logic [SR_W-1:0]   sr_wr_data,
  input  logic              cacr_wr_en,
  input  logic [CR_W-1:0]   cacr_wr_data,
  input  logic              a7_wr_en,
  input  logic [DATA_W-1:0] a7_wr_data,
  input  logic              bank_wr_en,
  input  logic [1:0]        bank_wr_sel,
  input  logic [DATA_W-1:0] bank_wr_data,
  output logic [DATA_W-1:0] a7_rd_data,
  output logic [1:0]        active_bank,
  output logic [SR_W-1:0]   sr_q,
  output logic [CR_W-1:0]   cacr_q
);
  import sp_bank_pkg::*;

  localparam logic [SR_W-1:0] RESET_SR = SYS_MODE ? SR_W'(16'h2700) : '0;

  logic              s_next, m_next, eusp_next;
  logic [1:0]        bank_next;
  logic [1:0]        bank_q;
  logic [DATA_W-1:0] a7_q;
  logic [DATA_W-1:0] live_val;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] slot_rd;
  logic              switching;

  sp_ctrl_regs #(
    .SR_W(SR_W), .CR_W(CR_W), .EUSP_BIT(EUSP_BIT), .RESET_SR(RESET_SR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .sr_we(sr_wr_en), .sr_wd(sr_wr_data),
    .cr_we(cacr_wr_en), .cr_wd(cacr_wr_data),
    .s_next(s_next), .m_next(m_next), .eusp_next(eusp_next),
    .sr_q(sr_q), .cr_q(cacr_q)
  );

  sp_mode_decode u_dec (
    .full_family(full_family), .s_next(s_next), .m_next(m_next),
    .eusp_next(eusp_next), .bank_next(bank_next)
  );

  assign switching = !rst && (bank_next != bank_q);

  // Live value of this cycle: A7 write, overridden by a bank write to the active slot.
  always_comb begin
    live_val = a7_wr_en ? a7_wr_data : a7_q;
    if (bank_wr_en && bank_wr_sel == bank_q) live_val = bank_wr_data;
  end

  // Value for A7 after a switch: a same-cycle bank write to the new slot bypasses the file.
  assign load_val = (bank_wr_en && bank_wr_sel == bank_next) ? bank_wr_data : slot_rd;

  sp_slot_file #(.DW(DATA_W), .NSLOT(BANK_NUM), .IW(BANK_IW)) u_slots (
    .clk(clk), .rst(rst),
    .save_en(switching), .save_idx(bank_q), .save_data(live_val),
    .bw_en(bank_wr_en && !rst), .bw_idx(bank_wr_sel), .bw_data(bank_wr_data),
    .rd_idx(bank_next), .rd_data(slot_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a7_q   <= '0;
      bank_q <= bank_next;
    end else begin
      a7_q   <= switching ? load_val : live_val;
      bank_q <= bank_next;
    end
  end

  assign a7_rd_data  = a7_q;
  assign active_bank = bank_q;
endmodule

// File: rtl/sp_bank_sel_chk.sv
module sp_bank_sel_chk #(
  parameter int DATA_W   = 32,
  parameter int SR_W     = 16,
  parameter int CR_W     = 32,
  parameter int EUSP_BIT = 31,
  parameter bit SYS_MODE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              full_family,
  input logic              sr_wr_en,
  input logic [SR_W-1:0]   sr_wr_data,
  input logic              cacr_wr_en,
  input logic [CR_W-1:0]   cacr_wr_data,
  input logic              a7_wr_en,
  input logic [DATA_W-1:0] a7_wr_data,
  input logic              bank_wr_en,
  input logic [1:0]        bank_wr_sel,
  input logic [DATA_W-1:0] bank_wr_data,
  input logic [DATA_W-1:0] a7_rd_data,
  input logic [1:0]        active_bank,
  input logic [SR_W-1:0]   sr_q,
  input logic [CR_W-1:0]   cacr_q
);
  import sp_bank_pkg::*;

  localparam logic [SR_W-1:0] EXP_SR = SYS_MODE ? SR_W'(16'h2700) : '0;

  logic unused_ok;
  assign unused_ok = ^{sr_wr_en, sr_wr_data, cacr_wr_en, cacr_wr_data};

  // R1
  reset_vals_chk: assert property (@(posedge clk)
    rst |=> (a7_rd_data == '0 && cacr_q == '0 && sr_q == EXP_SR));

  // R2 R3
  mode_sel_chk: assert property (@(posedge clk) disable iff (rst)
    active_bank == pick_bank($past(full_family), sr_q[SR_S_BIT], sr_q[SR_M_BIT], cacr_q[EUSP_BIT]));

  // R3
  reduced_no_isp_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(full_family) |-> active_bank != BANK_ISP);

  // R9
  bank_hit_live_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bank_wr_en && bank_wr_sel == active_bank) && $stable(active_bank))
      |-> a7_rd_data == $past(bank_wr_data));

  // R11
  a7_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!a7_wr_en && !bank_wr_en) && $stable(active_bank))
      |-> $stable(a7_rd_data));

  // R5
  a7_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a7_wr_en && !bank_wr_en) && $stable(active_bank))
      |-> a7_rd_data == $past(a7_wr_data));

  always_comb begin
    if (!rst) begin
      // R2
      idx_legal_chk: assert (active_bank != 2'd3 || $isunknown(active_bank));
    end
  end
endmodule

bind sp_bank_sel sp_bank_sel_chk #(
  .DATA_W(DATA_W), .SR_W(SR_W), .CR_W(CR_W), .EUSP_BIT(EUSP_BIT), .SYS_MODE(SYS_MODE)
) u_chk (.*);

// File: tb/tb_sp_bank_sel.sv
`timescale 1ns/1ps
module tb_sp_bank_sel;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          full_family = 1'b1;
  logic          sr_wr_en = 1'b0;
  logic [15:0]   sr_wr_data = '0;
  logic          cacr_wr_en = 1'b0;
  logic [31:0]   cacr_wr_data = '0;
  logic          a7_wr_en = 1'b0;
  logic [DW-1:0] a7_wr_data = '0;
  logic          bank_wr_en = 1'b0;
  logic [1:0]    bank_wr_sel = '0;
  logic [DW-1:0] bank_wr_data = '0;
  logic [DW-1:0] a7_rd_data;
  logic [1:0]    active_bank;
  logic [15:0]   sr_q;
  logic [31:0]   cacr_q;

  int checks = 0;
  int failures = 0;
  bit model_live = 0;

  always #2 clk = ~clk;

  sp_bank_sel dut (.*);

  // Behavioural reference model
  int unsigned m_slot [3];
  int unsigned m_a7;
  int unsigned m_sr, m_cr;
  int          m_idx;

  function automatic int want_idx(bit ff, int unsigned sr, int unsigned cr);
    bit s = sr[13];
    bit m = sr[12];
    if (ff) return s ? (m ? 0 : 2) : 1;
    return (s && cr[31]) ? 0 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sr = 32'h2700; m_cr = 0; m_a7 = 0;
      foreach (m_slot[k]) m_slot[k] = 0;
      m_idx = want_idx(full_family, m_sr, m_cr);
      model_live = 1;
    end else begin
      int unsigned live;
      int nidx;
      if (sr_wr_en) m_sr = sr_wr_data;
      if (cacr_wr_en) m_cr = cacr_wr_data;
      live = a7_wr_en ? a7_wr_data : m_a7;
      if (bank_wr_en && bank_wr_sel == m_idx) live = bank_wr_data;
      if (bank_wr_en && bank_wr_sel != 3) m_slot[bank_wr_sel] = bank_wr_data;
      nidx = want_idx(full_family, m_sr, m_cr);
      if (nidx != m_idx) begin
        m_slot[m_idx] = live;
        m_a7 = m_slot[nidx];
      end else begin
        m_a7 = live;
      end
      m_idx = nidx;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_live) begin
      check("MODEL a7 (R4)", a7_rd_data, m_a7);
      check("MODEL bank (R2/R3)", active_bank, m_idx);
      check("MODEL sr (R11)", sr_q, m_sr[15:0]);
    end
  end

  task automatic wr_sr(input [15:0] v);
    sr_wr_en = 1; sr_wr_data = v; @(negedge clk); sr_wr_en = 0;
  endtask
  task automatic wr_cr(input [31:0] v);
    cacr_wr_en = 1; cacr_wr_data = v; @(negedge clk); cacr_wr_en = 0;
  endtask
  task automatic wr_a7(input [DW-1:0] v);
    a7_wr_en = 1; a7_wr_data = v; @(negedge clk); a7_wr_en = 0;
  endtask
  task automatic wr_bank(input [1:0] s, input [DW-1:0] v);
    bank_wr_en = 1; bank_wr_sel = s; bank_wr_data = v; @(negedge clk); bank_wr_en = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 sr", sr_q, 16'h2700);
    check("R1 cacr", cacr_q, 0);
    check("R1 a7", a7_rd_data, 0);
    check("R1 bank full", active_bank, 2);

    wr_a7(32'h1111_0002);
    // R5: old value visible during the switching cycle
    sr_wr_en = 1; sr_wr_data = 16'h3700;
    #1 check("R5 a7 in switch cycle", a7_rd_data, 32'h1111_0002);
    @(negedge clk); sr_wr_en = 0;
    check("R5 a7 after switch", a7_rd_data, 0);
    check("R2 master", active_bank, 0);

    wr_a7(32'hAAAA_0000);
    wr_sr(16'h0000);
    check("R2 user", active_bank, 1);
    wr_a7(32'h5555_0001);
    wr_sr(16'h2000);
    check("R2 interrupt", active_bank, 2);
    check("R4 isp restored", a7_rd_data, 32'h1111_0002);
    wr_sr(16'h3000);
    check("R4 msp restored", a7_rd_data, 32'hAAAA_0000);

    wr_sr(16'h3F1F);
    check("R11 bank", active_bank, 0);
    check("R11 a7", a7_rd_data, 32'hAAAA_0000);

    a7_wr_en = 1; a7_wr_data = 32'hBEEF_0000;
    sr_wr_en = 1; sr_wr_data = 16'h2000;
    @(negedge clk); a7_wr_en = 0; sr_wr_en = 0;
    check("R7 loaded isp", a7_rd_data, 32'h1111_0002);
    wr_sr(16'h3000);
    check("R7 saved value", a7_rd_data, 32'hBEEF_0000);

    wr_bank(2'd1, 32'h0123_4567);
    check("R8 a7 untouched", a7_rd_data, 32'hBEEF_0000);
    wr_sr(16'h0000);
    check("R8 slot value", a7_rd_data, 32'h0123_4567);

    a7_wr_en = 1; a7_wr_data = 32'h9;
    bank_wr_en = 1; bank_wr_sel = 2'd1; bank_wr_data = 32'h77;
    @(negedge clk); a7_wr_en = 0; bank_wr_en = 0;
    check("R9 bank wins", a7_rd_data, 32'h77);

    bank_wr_en = 1; bank_wr_sel = 2'd2; bank_wr_data = 32'hCAFE;
    sr_wr_en = 1; sr_wr_data = 16'h2000;
    @(negedge clk); bank_wr_en = 0; sr_wr_en = 0;
    check("R10 bypass", a7_rd_data, 32'hCAFE);
    check("R10 bank", active_bank, 2);

    wr_cr(32'h8000_0000);
    check("R6 full no switch", active_bank, 2);

    full_family = 0;
    @(negedge clk);
    check("R3 reduced super", active_bank, 0);
    check("R3 a7", a7_rd_data, 32'hBEEF_0000);
    wr_cr(32'h0);
    check("R6 cacr switch", active_bank, 1);
    check("R6 a7", a7_rd_data, 32'h77);
    wr_sr(16'h3000);
    check("R3 no eusp", active_bank, 1);
    wr_cr(32'h8000_0000);
    check("R3 eusp set", active_bank, 0);
    check("R4 reduced restore", a7_rd_data, 32'hBEEF_0000);
    wr_sr(16'h0000);
    check("R3 user", active_bank, 1);

    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 bank reduced", active_bank, 1);
    check("R1 a7 again", a7_rd_data, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule